// File: doc/BRIEF.md
# Line-Frequency Real-Time Clock

This block is the programmable real-time clock of an 18-bit processor's I/O subsystem. A prescaler divides the system clock down to a tick strobe at 50 or 60 ticks per second. While software has the clock switched on, every tick adds one to an 18-bit counter. When the counter rolls over from all ones to zero, an overflow flag is set, and that flag drives the interrupt request line.

The processor controls the block through decoded I/O pulses. A 6-bit pulse field arrives with a strobe. One bit asks whether the flag is set and answers with a combinational skip. One bit clears the flag and turns the clock on or off, with a second bit choosing which. One bit presets the counter from the data bus. Software usually presets a negative count, so that the overflow arrives after a chosen number of ticks.

A separate clear-all-flags input clears the overflow flag but leaves the on/off state alone. The asynchronous reset clears everything. The tick rate is written as a plain number and only 50 or 60 is accepted.

Top module: `rtc_line_clock`

## Requirements
- R1: After reset the counter is 0, the flag and `irq` are 0, the clock is off (`running` = 0) and the rate select reads 60 (`rate60` = 1).
- R2: `io_skip` is 1 exactly while `io_strobe` is high, `io_pulse[0]` is set and the overflow flag is set. It is combinational and has no cycle of delay.
- R3: A strobe with `io_pulse[2]` set clears the flag at the next edge. The same edge turns the clock on if `io_pulse[5]` is 1 and off if it is 0.
- R4: A strobe with `io_pulse[1]` set loads `io_data` into the counter at the next edge. A load wins over an increment in the same cycle.
- R5: On each tick while the clock is on, the counter increments by one modulo 2^18.
- R6: The flag is set when an increment wraps the counter to zero. It stays set until it is cleared, and a wrap in the same cycle as a clear leaves it set. A load of zero does not set it.
- R7: While the clock is off, ticks have no effect: the counter holds its value.
- R8: A rate write (`rate_wr`) with `rate_val` = 60 selects 60 Hz and one with `rate_val` = 50 selects 50 Hz. Any other value is ignored and the previous selection stays.
- R9: Successive ticks are SYS_HZ/60 system clocks apart at 60 Hz and SYS_HZ/50 apart at 50 Hz.
- R10: `clr_flags` clears the flag at the next edge and leaves `running` unchanged.
- R11: `irq` reflects the overflow flag register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_strobe | input | 1 | Qualifies io_pulse for one cycle |
| io_pulse | input | 6 | Decoded pulse bits: 0 test, 1 load, 2 on/off plus flag clear, 5 on-select |
| io_data | input | 18 | Preset value for the counter |
| clr_flags | input | 1 | Clear-all-flags operation |
| rate_wr | input | 1 | Write strobe for the tick rate |
| rate_val | input | 7 | Requested ticks per second |
| io_skip | output | 1 | Skip answer to a flag test |
| irq | output | 1 | Interrupt request, the overflow flag |
| count | output | 18 | Counter value |
| running | output | 1 | Clock on/off state |
| rate60 | output | 1 | 1 when 60 Hz is selected, 0 for 50 Hz |

## Verification
The properties assume that a pulse lasts one cycle with `io_strobe`, and that any bit-1 load is visible to them as a strobe input. The stimulus issues every command for exactly one clock, driven on the falling edge. Counter and flag expectations are pushed only just after an observed tick, and the next tick is at least 100 cycles away. So a command never lands in the same cycle as a tick, and the bench never has to predict the prescaler phase. Tick spacing is measured only between two observed counter changes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int CNT_W   = 18;
    localparam int PULSE_W = 6;
    localparam int RATE_W  = 7;

    localparam int P_TEST  = 0;
    localparam int P_LOAD  = 1;
    localparam int P_ONOFF = 2;
    localparam int P_ONSEL = 5;

    localparam logic [RATE_W-1:0] RATE_50 = 7'd50;
    localparam logic [RATE_W-1:0] RATE_60 = 7'd60;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             flag;
        logic             en;
    } core_state_t;
endpackage

// File: rtl/rtc_rate_reg.sv
module rtc_rate_reg
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [RATE_W-1:0] val,
    output logic              sel60
);
    logic sel60_d, sel60_q;

    always_comb begin
        sel60_d = sel60_q;
        if (wr) begin
            if (val == RATE_60)      sel60_d = 1'b1;
            else if (val == RATE_50) sel60_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel60_q <= 1'b1;
        else        sel60_q <= sel60_d;
    end

    assign sel60 = sel60_q;
endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
    parameter int SYS_HZ = 6000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel60,
    output logic tick
);
    localparam int TC50 = SYS_HZ / 50 - 1;
    localparam int TC60 = SYS_HZ / 60 - 1;
    localparam int PW   = $clog2(TC50 + 1);

    logic [PW-1:0] cnt_d, cnt_q;
    logic [PW-1:0] term;
    logic          tick_c;

    always_comb begin
        term   = sel60 ? PW'(TC60) : PW'(TC50);
        tick_c = (cnt_q >= term);
        cnt_d  = tick_c ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = tick_c;
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmd_onoff,
    input  logic             on_sel,
    input  logic             cmd_load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clr_all,
    output core_state_t      st
);
    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_onoff) begin
            st_d.flag = 1'b0;
            st_d.en   = on_sel;
        end
        if (clr_all) st_d.flag = 1'b0;
        if (cmd_load) begin
            st_d.count = load_val;
        end else if (tick && st_q.en) begin
            st_d.count = st_q.count + 1'b1;
            if (st_d.count == '0) st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/rtc_line_clock.sv
module rtc_line_clock
    import rtc_pkg::*;
#(
    parameter int SYS_HZ = 6000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_strobe,
    input  logic [PULSE_W-1:0] io_pulse,
    input  logic [CNT_W-1:0]   io_data,
    input  logic               clr_flags,
    input  logic               rate_wr,
    input  logic [RATE_W-1:0]  rate_val,
    output logic               io_skip,
    output logic               irq,
    output logic [CNT_W-1:0]   count,
    output logic               running,
    output logic               rate60
);
    logic        sel60;
    logic        tick;
    core_state_t st;

    rtc_rate_reg u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (rate_wr),
        .val   (rate_val),
        .sel60 (sel60)
    );

    rtc_tick_gen #(.SYS_HZ(SYS_HZ)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .sel60 (sel60),
        .tick  (tick)
    );

    rtc_count_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cmd_onoff (io_strobe && io_pulse[P_ONOFF]),
        .on_sel    (io_pulse[P_ONSEL]),
        .cmd_load  (io_strobe && io_pulse[P_LOAD]),
        .load_val  (io_data),
        .clr_all   (clr_flags),
        .st        (st)
    );

    assign io_skip = io_strobe && io_pulse[P_TEST] && st.flag;
    assign irq     = st.flag;
    assign count   = st.count;
    assign running = st.en;
    assign rate60  = sel60;
endmodule

// File: rtl/rtc_line_clock_chk.sv
module rtc_line_clock_chk
    import rtc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               io_strobe,
    input logic [PULSE_W-1:0] io_pulse,
    input logic               clr_flags,
    input logic               rate_wr,
    input logic               irq,
    input logic [CNT_W-1:0]   count,
    input logic               running,
    input logic               rate60
);
    // R6
    flag_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (count == '0));

    // R7
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !(io_strobe && io_pulse[P_LOAD])) |=> $stable(count));

    // R5
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !(io_strobe && io_pulse[P_LOAD]))
        |=> (count == $past(count) || count == $past(count) + 1'b1));

    // R3
    turn_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_strobe && io_pulse[P_ONOFF] && io_pulse[P_ONSEL]) |=> running);

    // R10
    clear_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flags && !io_strobe) |=> (running == $past(running)));

    // R8
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_wr |=> $stable(rate60));
endmodule

bind rtc_line_clock rtc_line_clock_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_strobe (io_strobe),
    .io_pulse  (io_pulse),
    .clr_flags (clr_flags),
    .rate_wr   (rate_wr),
    .irq       (irq),
    .count     (count),
    .running   (running),
    .rate60    (rate60)
);

// File: tb/test_rtc_line_clock.sv
module test_rtc_line_clock;
    localparam int SYS_HZ = 6000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_strobe = 1'b0;
    logic [5:0]  io_pulse = '0;
    logic [17:0] io_data = '0;
    logic        clr_flags = 1'b0;
    logic        rate_wr = 1'b0;
    logic [6:0]  rate_val = '0;
    logic        io_skip, irq, running, rate60;
    logic [17:0] count;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        string       req;
        logic [17:0] cnt;
        logic        irq;
        logic        run;
        logic        r60;
        logic        skip;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    rtc_line_clock #(.SYS_HZ(SYS_HZ)) i_rtc_line_clock (
        .clk(clk), .rst_n(rst_n), .io_strobe(io_strobe), .io_pulse(io_pulse),
        .io_data(io_data), .clr_flags(clr_flags), .rate_wr(rate_wr),
        .rate_val(rate_val), .io_skip(io_skip), .irq(irq), .count(count),
        .running(running), .rate60(rate60)
    );

    // monitor: compares one expected item per cycle, 3 ns after the edge
    always @(posedge clk) begin
        #3;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (count !== e.cnt || irq !== e.irq || running !== e.run ||
                rate60 !== e.r60 || io_skip !== e.skip) begin
                n_fail++;
                $display("FAIL %s: got cnt=%h irq=%b run=%b r60=%b skip=%b exp cnt=%h irq=%b run=%b r60=%b skip=%b",
                         e.req, count, irq, running, rate60, io_skip,
                         e.cnt, e.irq, e.run, e.r60, e.skip);
            end
        end
    end

    task automatic expect_st(string req, logic [17:0] c, logic i, logic r,
                             logic r6, logic s);
        exp_t e;
        e.req = req; e.cnt = c; e.irq = i; e.run = r; e.r60 = r6; e.skip = s;
        sb.push_back(e);
    endtask

    task automatic pulse_op(logic [5:0] p, logic [17:0] d);
        io_strobe = 1'b1; io_pulse = p; io_data = d;
    endtask

    task automatic end_op();
        @(negedge clk);
        io_strobe = 1'b0; io_pulse = '0; clr_flags = 1'b0; rate_wr = 1'b0;
    endtask

    task automatic wait_change(output int n);
        logic [17:0] prev;
        prev = count;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (count == prev && n < 1000);
    endtask

    task automatic chk_gap(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: tick gap got %0d exp %0d", req, got, exp);
        end
    endtask

    initial begin
        int gap;
        repeat (3) @(negedge clk);
        // R1 reset state
        expect_st("R1", 18'h0, 0, 0, 1, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R7 ticks ignored while off
        repeat (300) @(negedge clk);
        expect_st("R7", 18'h0, 0, 0, 1, 0);
        @(negedge clk);
        // R4 load
        pulse_op(6'b000010, 18'h3FFFD);
        expect_st("R4", 18'h3FFFD, 0, 0, 1, 0);
        end_op();
        // R3 turn on
        pulse_op(6'b100100, '0);
        expect_st("R3", 18'h3FFFD, 0, 1, 1, 0);
        end_op();
        // R5 increments
        wait_change(gap);
        expect_st("R5", 18'h3FFFE, 0, 1, 1, 0);
        wait_change(gap);
        chk_gap("R9", gap, SYS_HZ / 60);
        expect_st("R5", 18'h3FFFF, 0, 1, 1, 0);
        wait_change(gap);
        // R6 and R11 wrap sets flag / irq
        expect_st("R6", 18'h0, 1, 1, 1, 0);
        @(negedge clk);
        // R2 skip while flag set
        pulse_op(6'b000001, '0);
        expect_st("R2", 18'h0, 1, 1, 1, 1);
        end_op();
        // R10 clear-all keeps running
        clr_flags = 1'b1;
        expect_st("R10", 18'h0, 0, 1, 1, 0);
        end_op();
        // R2 no skip when flag clear
        pulse_op(6'b000001, '0);
        expect_st("R2", 18'h0, 0, 1, 1, 0);
        end_op();
        wait_change(gap);
        expect_st("R6", 18'h1, 0, 1, 1, 0);
        @(negedge clk);
        // R4 load while running
        pulse_op(6'b000010, 18'h3FFFF);
        expect_st("R4", 18'h3FFFF, 0, 1, 1, 0);
        end_op();
        wait_change(gap);
        expect_st("R11", 18'h0, 1, 1, 1, 0);
        @(negedge clk);
        // R3 off command clears flag and stops
        pulse_op(6'b000100, '0);
        expect_st("R3", 18'h0, 0, 0, 1, 0);
        end_op();
        repeat (300) @(negedge clk);
        expect_st("R7", 18'h0, 0, 0, 1, 0);
        @(negedge clk);
        // R8 invalid rate rejected
        rate_wr = 1'b1; rate_val = 7'd45;
        expect_st("R8", 18'h0, 0, 0, 1, 0);
        end_op();
        rate_wr = 1'b1; rate_val = 7'd50;
        expect_st("R8", 18'h0, 0, 0, 0, 0);
        end_op();
        pulse_op(6'b100100, '0);
        expect_st("R3", 18'h0, 0, 1, 0, 0);
        end_op();
        wait_change(gap);
        wait_change(gap);
        chk_gap("R9", gap, SYS_HZ / 50);
        expect_st("R5", 18'h2, 0, 1, 0, 0);
        @(negedge clk);
        // R1 reset mid-run after a wrap
        pulse_op(6'b000010, 18'h3FFFF);
        end_op();
        wait_change(gap);
        expect_st("R6", 18'h0, 1, 1, 0, 0);
        @(negedge clk);
        rst_n = 1'b0;
        expect_st("R1", 18'h0, 0, 0, 1, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout exp completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule